// File: doc/BRIEF.md
# Phase-Interleaved Two-Wire Function Link

This block halves the wiring needed to move a set of single-bit function results from a main logic chip to a peripheral chip. The main side holds a group of function bits and sends them over half as many shared wires. A phase signal alternates on every clock. In the even phase, each shared wire carries the first function of its pair. In the odd phase, it carries the second.

The peripheral side watches the phase signal and the shared wires. It sorts the wire values into holding registers and presents all function bits side by side. A valid flag marks the point where the reconstructed outputs first reflect sampled input data. Both sides are instantiated together in one top module, so their connection can be checked as a unit. The functions themselves are computed elsewhere and enter through `func_in`.

The default build has LINES = 2, so four function bits travel over two wires. Function bit 2i rides wire i in the even phase, and bit 2i+1 rides wire i in the odd phase.

Two small state machines make up the control:

- **Phase generator.** It has states PH_EVEN (eta = 0) and PH_ODD (eta = 1).
  - Transition ADVANCE moves PH_EVEN to PH_ODD.
  - Transition WRAP moves PH_ODD back to PH_EVEN.
  - Reset forces PH_EVEN.
- **Peripheral state machine.** It has states RX_FLUSH, RX_FILL and RX_LIVE. It only moves on the clock edge that ends an odd-phase cycle.
  - Transition PRIMED moves RX_FLUSH to RX_FILL. It fires at the end of the first pair, which carries the cleared hold contents.
  - Transition SETTLED moves RX_FILL to RX_LIVE.
  - RX_LIVE stays where it is.
  - Reset forces RX_FLUSH.

Top module: `tmx_link`

## Requirements
- R1: `eta` is 0 in the first cycle after synchronous reset is released, and it inverts on every rising clock edge after that.
- R2: Wire i of `link_line` equals `func_in` bit 2i (as held) while `eta` is 0. It equals bit 2i+1 (as held) while `eta` is 1.
- R3: The main side samples `func_in` only on the clock edge that ends an `eta`=1 cycle. Any change to `func_in` during the `eta`=0 cycle has no effect on either phase of the pair being sent.
- R4: The peripheral stores wire i into output slot 2i on the edge that ends an `eta`=0 cycle. It stores wire i into slot 2i+1 on the edge that ends an `eta`=1 cycle.
- R5: `func_out` changes only on the edge that ends an `eta`=1 cycle, and all of its bits change together then. It is unchanged across the edge that ends an `eta`=0 cycle.
- R6: A vector sampled by the main side at edge E appears in full on `func_out` after edge E+2. That is two phases later.
- R7: `out_valid` is 0 from reset until the edge that ends the second `eta`=1 cycle after reset. From then on it stays 1 until the next reset.
- R8: While reset is asserted, `eta`, `link_line`, `func_out` and `out_valid` are all 0 after the next clock edge.
- R9: The number of shared wires is LINES, which is half the number of function bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| func_in | input | 2*LINES | Function results on the main side |
| eta | output | 1 | Phase signal shared by both sides |
| link_line | output | LINES | Shared time-multiplexed wires |
| func_out | output | 2*LINES | Reconstructed function bits on the peripheral side |
| out_valid | output | 1 | High once the outputs carry sampled data |

## Verification
Two events can land on the same clock edge: the main side loading a new input vector, and the peripheral committing the previous vector to `func_out`. Both happen at the edge that ends each `eta`=1 cycle. The bench provokes this by presenting a fresh vector in every odd cycle, sweeping all sixteen four-bit values. In the even cycle in between, it drives the complement of the vector as a decoy. It then judges the coincidence by checking that the wires in the next pair carry only the new vector, while `func_out` shows exactly the vector from the pair before.

// File: rtl/tmx_pkg.sv
package tmx_pkg;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_t;

    typedef enum logic [1:0] {
        RX_FLUSH = 2'd0,
        RX_FILL  = 2'd1,
        RX_LIVE  = 2'd2
    } rx_state_t;

endpackage

// File: rtl/tmx_phase_gen.sv
module tmx_phase_gen
    import tmx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic eta
);

    phase_t state_q;
    phase_t state_d;

    // next-state selection: ADVANCE and WRAP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_EVEN: state_d = PH_ODD;
            PH_ODD:  state_d = PH_EVEN;
            default: state_d = PH_EVEN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_EVEN;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PH_EVEN: eta = 1'b0;
            PH_ODD:  eta = 1'b1;
            default: eta = 1'b0;
        endcase
    end

    AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (!rst) |=> (eta != $past(eta)));  // R1

    AST_RESET_PHASE: assert property (@(posedge clk)
        rst |=> !eta);  // R8

endmodule

// File: rtl/tmx_main_side.sv
module tmx_main_side #(
    parameter int LINES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               eta,
    input  logic [2*LINES-1:0] func_in,
    output logic [LINES-1:0]   line
);

    localparam int FUNCS = 2 * LINES;

    logic [FUNCS-1:0] hold_q;

    // load a coherent vector only on the edge that closes the odd phase
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (eta) begin
            hold_q <= func_in;
        end
    end

    // one pair of held bits per shared wire, steered by the phase
    for (genvar i = 0; i < LINES; i++) begin : g_wire
        always_comb begin
            line[i] = eta ? hold_q[2*i+1] : hold_q[2*i];
        end
    end

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!eta) |=> $stable(hold_q));  // R3

endmodule

// File: rtl/tmx_periph_side.sv
module tmx_periph_side
    import tmx_pkg::*;
#(
    parameter int LINES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               eta,
    input  logic [LINES-1:0]   line,
    output logic [2*LINES-1:0] func_out,
    output logic               out_valid
);

    localparam int FUNCS = 2 * LINES;

    rx_state_t        state_q;
    rx_state_t        state_d;
    logic [LINES-1:0] even_q;
    logic [FUNCS-1:0] out_q;

    // next-state selection: PRIMED, SETTLED
    always_comb begin
        state_d = state_q;
        if (eta) begin
            unique case (state_q)
                RX_FLUSH: state_d = RX_FILL;
                RX_FILL:  state_d = RX_LIVE;
                RX_LIVE:  state_d = RX_LIVE;
                default:  state_d = RX_FLUSH;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_FLUSH;
        end else begin
            state_q <= state_d;
        end
    end

    // receiving slots: even slots wait in even_q, all slots commit at odd end
    for (genvar i = 0; i < LINES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                even_q[i]      <= 1'b0;
                out_q[2*i]     <= 1'b0;
                out_q[2*i+1]   <= 1'b0;
            end else if (!eta) begin
                even_q[i]      <= line[i];
            end else begin
                out_q[2*i]     <= even_q[i];
                out_q[2*i+1]   <= line[i];
            end
        end
    end

    // outputs
    always_comb begin
        func_out = out_q;
        unique case (state_q)
            RX_FLUSH: out_valid = 1'b0;
            RX_FILL:  out_valid = 1'b0;
            RX_LIVE:  out_valid = 1'b1;
            default:  out_valid = 1'b0;
        endcase
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!eta) |=> $stable(func_out));  // R5

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);  // R7

    for (genvar i = 0; i < LINES; i++) begin : g_chk
        AST_ODD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
            eta |=> (func_out[2*i+1] == $past(line[i])));  // R4

        AST_EVEN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
            eta |=> (func_out[2*i] == $past(line[i], 2)));  // R4
    end

endmodule

// File: rtl/tmx_link.sv
module tmx_link #(
    parameter int LINES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2*LINES-1:0] func_in,
    output logic               eta,
    output logic [LINES-1:0]   link_line,
    output logic [2*LINES-1:0] func_out,
    output logic               out_valid
);

    localparam int FUNCS = 2 * LINES;

    tmx_phase_gen u_phase (
        .clk (clk),
        .rst (rst),
        .eta (eta)
    );

    tmx_main_side #(.LINES(LINES)) u_main (
        .clk     (clk),
        .rst     (rst),
        .eta     (eta),
        .func_in (func_in),
        .line    (link_line)
    );

    tmx_periph_side #(.LINES(LINES)) u_periph (
        .clk       (clk),
        .rst       (rst),
        .eta       (eta),
        .line      (link_line),
        .func_out  (func_out),
        .out_valid (out_valid)
    );

    initial begin
        AST_WIRE_COUNT: assert ($bits(link_line) * 2 == FUNCS);  // R9
    end

    for (genvar i = 0; i < LINES; i++) begin : g_link_chk
        AST_EVEN_WIRE: assert property (@(posedge clk) disable iff (rst)
            eta |=> (link_line[i] == $past(func_in[2*i])));  // R2
    end

endmodule

// File: tb/tmx_link_test.sv
`timescale 1ns/1ps
module tmx_link_test;

    localparam int LINES = 2;
    localparam int FUNCS = 2 * LINES;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [FUNCS-1:0] func_in = '0;
    logic             eta;
    logic [LINES-1:0] link_line;
    logic [FUNCS-1:0] func_out;
    logic             out_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    tmx_link #(.LINES(LINES)) uut (
        .clk       (clk),
        .rst       (rst),
        .func_in   (func_in),
        .eta       (eta),
        .link_line (link_line),
        .func_out  (func_out),
        .out_valid (out_valid)
    );

    always #10 clk = ~clk;

    function automatic logic [LINES-1:0] pick(input logic [FUNCS-1:0] v, input int odd);
        logic [LINES-1:0] r;
        for (int i = 0; i < LINES; i++) r[i] = v[2*i+odd];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [FUNCS-1:0] prev;
        logic [FUNCS-1:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(eta == 1'b0, "R8 eta", eta, 0);
        check(link_line == '0, "R8 lines", link_line, 0);
        check(func_out == '0, "R8 outputs", func_out, 0);
        check(out_valid == 1'b0, "R8 valid", out_valid, 0);
        rst = 1'b0;
        check(eta == 1'b0, "R1 first phase", eta, 0);
        @(negedge clk);
        check(eta == 1'b1, "R1 toggle", eta, 1);
        prev = '0;
        func_in = 4'h0;
        for (int k = 0; k < 16; k++) begin
            v = k[FUNCS-1:0];
            @(negedge clk);
            check(eta == 1'b0, "R1 even", eta, 0);
            check(link_line == pick(v, 0), "R2 even wires", link_line, pick(v, 0));
            check(func_out == prev, "R4,R6 outputs", func_out, prev);
            check(out_valid == (k >= 1), "R7 valid", out_valid, (k >= 1));
            func_in = ~v;
            @(negedge clk);
            check(eta == 1'b1, "R1 odd", eta, 1);
            check(link_line == pick(v, 1), "R3 odd wires ignore decoy", link_line, pick(v, 1));
            check(func_out == prev, "R5 outputs held", func_out, prev);
            prev = v;
            func_in = (k + 1) % 16;
        end
        @(negedge clk);
        check(func_out == prev, "R6 last vector", func_out, prev);
        check(out_valid == 1'b1, "R7 valid stays", out_valid, 1);
        rst = 1'b1;
        @(negedge clk);
        check(eta == 1'b0, "R8 eta mid-run", eta, 0);
        check(func_out == '0, "R8 outputs mid-run", func_out, 0);
        check(out_valid == 1'b0, "R8 valid mid-run", out_valid, 0);
        check(link_line == '0, "R8 lines mid-run", link_line, 0);
        func_in = 4'hA;
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7 valid after one pair", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R7 valid after two pairs", out_valid, 1);
        check(func_out == 4'hA, "R6 after reset", func_out, 4'hA);
        check($bits(link_line) * 2 == FUNCS, "R9 wire count", $bits(link_line), FUNCS / 2);
        finish_run();
    end

endmodule